// File: doc/BRIEF.md
# Buffered Parallel I/O Port Controller

This block gives a host a 24-line general-purpose parallel port through four byte-wide registers. The lines form four groups: two full-width ports, A and B, and a third port, C, split into an upper and a lower half. Each group is set as input or output on its own. Output groups present a write latch on the pins, and input groups are read straight from the pins with no sampling register in the path. Only the plain, non-handshake operating mode exists.

The external lines pass through bidirectional buffers with pull-ups. Besides the direction bits, the control register holds a global tristate latch for those buffers. A control write that carries the configuration flag loads new directions, clears every output latch and puts all buffers in high impedance in the same step. Software then fills the output latches and issues a control write without the flag. That write changes nothing except to re-enable the buffers, so new output values reach the pins together. Pins come out as separate value, enable and input vectors for a pad ring or an external transceiver.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset every group is an input, the tristate latch is clear, all output latches hold 0, no pin is enabled, and the control register reads 0x1B.
- R2: Direction bits of a control byte (1 = input, 0 = output) are bit 4 for port A, bit 1 for port B, bit 3 for C upper (pins 23..20) and bit 0 for C lower (pins 19..16). Port A uses pins 7..0 and port B uses pins 15..8.
- R3: A control write (offset 3) with bit 7 = 1 loads all four direction bits, sets the tristate latch so that pin_oe is all zero, and clears every output latch to 0.
- R4: A control write with bit 7 = 0 clears the tristate latch and leaves the direction bits and all output latches unchanged, whatever its other bits hold.
- R5: A pin's enable is 1 only when its group is an output and the tristate latch is clear. pin_out always carries the group's output latch.
- R6: A write to offset 0 latches port A and a write to offset 1 latches port B. A write to offset 2 latches C upper from data bits 7..4 and C lower from bits 3..0. Latches written while tristated appear on the enabled pins once the buffers are re-enabled.
- R7: Reading an input group returns the present pin_in value. The value follows the pins with no write in between.
- R8: Reading an output group returns its output latch. Port C mixes the two halves bit by bit according to their directions.
- R9: Reading offset 3 returns the direction bits at the positions in R2 and the tristate latch in bit 7. Bits 6, 5 and 2 read 0 whatever was written to them.
- R10: A write changes state at the clock edge where bus_wr is sampled high. Reads are combinational, so in the write cycle itself the read still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset: 0 A, 1 B, 2 C, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 24 | Levels sensed at the external lines |
| pin_out | output | 24 | Output latch values for the lines |
| pin_oe | output | 24 | Per-line drive enable, 1 = drive |

## Verification
Each register write takes effect at the one clock edge where bus_wr is high. The bench holds the strobe for one cycle from a falling edge and checks pin_out, pin_oe and the control readback at the next falling edge, after that single register stage. Reads have no latency, so the bench sets bus_addr, waits a short settle delay inside the same low phase, and samples bus_rdata there. One check looks inside the write cycle itself to confirm that the old value is still visible before the edge.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // group indices used for direction vectors
  localparam int GRP_N  = 4;
  localparam int GRP_A  = 0;
  localparam int GRP_B  = 1;
  localparam int GRP_CH = 2;
  localparam int GRP_CL = 3;

  // control byte bit positions (software-visible encoding)
  localparam int CB_TS  = 7;
  localparam int CB_A   = 4;
  localparam int CB_CH  = 3;
  localparam int CB_B   = 1;
  localparam int CB_CL  = 0;

  typedef enum logic [1:0] {
    REG_PA  = 2'd0,
    REG_PB  = 2'd1,
    REG_PC  = 2'd2,
    REG_CTL = 2'd3
  } pio_reg_e;

  // control byte -> per-group direction (1 = input)
  function automatic logic [GRP_N-1:0] ctl_to_dir(input logic [7:0] cb);
    logic [GRP_N-1:0] d;
    d[GRP_A]  = cb[CB_A];
    d[GRP_B]  = cb[CB_B];
    d[GRP_CH] = cb[CB_CH];
    d[GRP_CL] = cb[CB_CL];
    return d;
  endfunction

  // per-group direction + tristate latch -> control readback byte
  function automatic logic [7:0] dir_to_ctl(input logic [GRP_N-1:0] d, input logic ts);
    logic [7:0] cb;
    cb        = 8'h00;
    cb[CB_TS] = ts;
    cb[CB_A]  = d[GRP_A];
    cb[CB_B]  = d[GRP_B];
    cb[CB_CH] = d[GRP_CH];
    cb[CB_CL] = d[GRP_CL];
    return cb;
  endfunction

endpackage

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [GRP_N-1:0] dir_in,
  output logic             tri_on,
  output logic             cfg_load
);

  // a configuring write: flag bit set
  assign cfg_load = ctl_we & ctl_wdata[CB_TS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_in <= '1;
      tri_on <= 1'b0;
    end else if (ctl_we) begin
      if (ctl_wdata[CB_TS]) begin
        dir_in <= ctl_to_dir(ctl_wdata);
        tri_on <= 1'b1;
      end else begin
        tri_on <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (we)  q <= d;
  end

endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
  import pio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic [1:0]          addr,
  input  logic [3*PORT_W-1:0] grp_rd,
  input  logic [7:0]          ctl_byte,
  output logic [PORT_W-1:0]   rdata
);

  always_comb begin
    rdata = '0;
    unique case (pio_reg_e'(addr))
      REG_PA:  rdata = grp_rd[0 +: PORT_W];
      REG_PB:  rdata = grp_rd[PORT_W +: PORT_W];
      REG_PC:  rdata = grp_rd[2*PORT_W +: PORT_W];
      REG_CTL: rdata[7:0] = ctl_byte;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
  import pio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [PORT_W-1:0]   bus_wdata,
  output logic [PORT_W-1:0]   bus_rdata,
  input  logic [3*PORT_W-1:0] pin_in,
  output logic [3*PORT_W-1:0] pin_out,
  output logic [3*PORT_W-1:0] pin_oe
);

  localparam int HALF_W = PORT_W / 2;
  localparam int PIN_N  = 3 * PORT_W;

  logic [GRP_N-1:0] dir_in;
  logic             tri_on;
  logic             cfg_load;
  logic             ctl_we;
  logic [7:0]       ctl_byte;
  logic [PIN_N-1:0] grp_rd;

  assign ctl_we   = bus_wr && (pio_reg_e'(bus_addr) == REG_CTL);
  assign ctl_byte = dir_to_ctl(dir_in, tri_on);

  pio_ctrl_reg i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_wdata(bus_wdata[7:0]),
    .dir_in   (dir_in),
    .tri_on   (tri_on),
    .cfg_load (cfg_load)
  );

  // one latch per group; width, pin offset, register and data slice per group
  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    localparam int GW = (g < 2) ? PORT_W : HALF_W;
    localparam int GO = (g == GRP_A)  ? 0 :
                        (g == GRP_B)  ? PORT_W :
                        (g == GRP_CH) ? 2*PORT_W + HALF_W : 2*PORT_W;
    localparam int DO = (g == GRP_CH) ? HALF_W : 0;
    localparam logic [1:0] RSEL = (g == GRP_A) ? 2'(REG_PA) :
                                  (g == GRP_B) ? 2'(REG_PB) : 2'(REG_PC);
    logic          we_g;
    logic [GW-1:0] q_g;

    assign we_g = bus_wr && (bus_addr == RSEL);

    pio_out_latch #(.W(GW)) i_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cfg_load),
      .we   (we_g),
      .d    (bus_wdata[DO +: GW]),
      .q    (q_g)
    );

    assign pin_out[GO +: GW] = q_g;
    assign pin_oe[GO +: GW]  = {GW{~dir_in[g] & ~tri_on}};
    assign grp_rd[GO +: GW]  = dir_in[g] ? pin_in[GO +: GW] : q_g;
  end

  pio_read_mux #(.PORT_W(PORT_W)) i_rmux (
    .addr    (bus_addr),
    .grp_rd  (grp_rd),
    .ctl_byte(ctl_byte),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/pio_port_ctrl_chk.sv
module pio_port_ctrl_chk
  import pio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          bus_addr,
  input logic                bus_wr,
  input logic [PORT_W-1:0]   bus_wdata,
  input logic [PORT_W-1:0]   bus_rdata,
  input logic [3*PORT_W-1:0] pin_in,
  input logic [3*PORT_W-1:0] pin_out,
  input logic [3*PORT_W-1:0] pin_oe,
  input logic [GRP_N-1:0]    dir_in,
  input logic                tri_on
);

  logic cfg_wr, en_wr;
  assign cfg_wr = bus_wr && bus_addr == 2'd3 && bus_wdata[7];
  assign en_wr  = bus_wr && bus_addr == 2'd3 && !bus_wdata[7];

  AST_CFG_TRISTATES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (pin_oe == '0 && pin_out == '0)); // R3

  AST_CFG_LOADS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> dir_in == ctl_to_dir($past(bus_wdata[7:0]))); // R2

  AST_ENABLE_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (dir_in == $past(dir_in) && !tri_on && pin_out == $past(pin_out))); // R4

  AST_TRISTATE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    tri_on |-> pin_oe == '0); // R5

  AST_PORTA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> pin_out[PORT_W-1:0] == $past(bus_wdata)); // R6

  AST_INPUT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0 && dir_in[GRP_A]) |-> bus_rdata == pin_in[PORT_W-1:0]); // R7

  AST_OUTPUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1 && !dir_in[GRP_B]) |-> bus_rdata == pin_out[2*PORT_W-1:PORT_W]); // R8

  AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd3 |-> (bus_rdata[6:5] == 2'b00 && bus_rdata[2] == 1'b0)); // R9

endmodule

bind pio_port_ctrl pio_port_ctrl_chk #(.PORT_W(PORT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_in   (pin_in),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .dir_in   (dir_in),
  .tri_on   (tri_on)
);

// File: tb/test_pio_port_ctrl.sv
module test_pio_port_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [23:0] pin_in = 24'hFFFFFF;
  logic [23:0] pin_out;
  logic [23:0] pin_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pio_port_ctrl i_pio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  // cfg bit order here: [0]=A [1]=B [2]=C upper [3]=C lower, 1 = input
  function automatic logic [7:0] exp_ctl(input logic [3:0] c, input logic ts);
    return {ts, 2'b00, c[0], c[2], 1'b0, c[1], c[3]};
  endfunction

  function automatic logic [23:0] in_mask(input logic [3:0] c);
    return {{4{c[2]}}, {4{c[3]}}, {8{c[1]}}, {8{c[0]}}};
  endfunction

  initial begin
    logic [7:0] rv;
    logic [23:0] lat;
    logic [23:0] exp_rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    bus_read(2'd3, rv);
    check("R1", "ctl after reset", {16'h0, rv}, 24'h00001B);
    check("R1", "oe after reset", pin_oe, 24'h0);
    check("R1", "latches after reset", pin_out, 24'h0);

    // live inputs while everything is input
    pin_in = 24'h3C5AA5;
    bus_read(2'd0, rv); check("R7", "port A live", {16'h0, rv}, 24'h0000A5);
    bus_read(2'd2, rv); check("R7", "port C live", {16'h0, rv}, 24'h00003C);
    pin_in = 24'hC3817E;
    bus_read(2'd0, rv); check("R7", "port A follows pins", {16'h0, rv}, 24'h00007E);
    bus_read(2'd1, rv); check("R7", "port B follows pins", {16'h0, rv}, 24'h000081);

    for (int g = 0; g < 16; g++) begin
      logic [3:0] c;
      logic [7:0] cw, pa, pb, pc;
      c  = 4'(g);
      cw = {1'b1, c[0] ^ c[1], ~c[3], c[0], c[2], c[1] ^ c[2], c[1], c[3]};
      pa = 8'(g * 17) ^ 8'h5A;
      pb = ~pa;
      pc = {c, ~c} ^ 8'h96;

      bus_write(2'd3, cw);
      bus_read(2'd3, rv);
      check("R9", "ctl readback after config", {16'h0, rv}, {16'h0, exp_ctl(c, 1'b1)});
      check("R3", "oe off after config", pin_oe, 24'h0);
      check("R3", "latches cleared by config", pin_out, 24'h0);

      bus_write(2'd0, pa);
      bus_write(2'd1, pb);
      bus_write(2'd2, pc);
      lat = {pc, pb, pa};
      check("R5", "no drive while tristated", pin_oe, 24'h0);
      check("R6", "latches written while tristated", pin_out, lat);

      // enable write with junk in every other bit
      bus_write(2'd3, 8'h7F ^ {1'b0, 3'(g), 4'(g)});
      bus_read(2'd3, rv);
      check("R4", "enable keeps directions", {16'h0, rv}, {16'h0, exp_ctl(c, 1'b0)});
      check("R4", "enable keeps latches", pin_out, lat);
      check("R5", "oe per group", pin_oe, ~in_mask(c));

      pin_in = {8'(g) ^ 8'hE1, 8'h4D ^ 8'(g * 3), ~pa};
      exp_rd = (pin_in & in_mask(c)) | (lat & ~in_mask(c));
      bus_read(2'd0, rv); check("R8", "port A read", {16'h0, rv}, {16'h0, exp_rd[7:0]});
      bus_read(2'd1, rv); check("R8", "port B read", {16'h0, rv}, {16'h0, exp_rd[15:8]});
      bus_read(2'd2, rv); check("R8", "port C mixed read", {16'h0, rv}, {16'h0, exp_rd[23:16]});
    end

    // R10: old control value is visible during the write cycle
    @(negedge clk);
    bus_addr = 2'd3; bus_wdata = 8'h80; bus_wr = 1'b1;
    #1;
    check("R10", "ctl before edge", {16'h0, bus_rdata}, {16'h0, exp_ctl(4'hF, 1'b0)});
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    check("R10", "ctl after edge", {16'h0, bus_rdata}, 24'h000080);
    check("R2", "all outputs config", pin_oe, 24'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule